// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Controller

This block is the slave side of a byte-addressed serial memory on a two-wire bus (SCL clock, open-drain SDA data). SCL and SDA are sampled on the system clock, which must run several times faster than SCL. The block finds START and STOP conditions and decodes the device byte. It keeps one address counter that both writes and reads advance. The array is a synchronous RAM of `2**ADDR_W` bytes, 2048 by default.

Three read forms are supported. A current-address read picks up at the counter. A random read follows a write-mode header that carries only the two address bytes; a repeated START then turns the bus around. A sequential burst continues for as long as the master acknowledges, and it wraps through the whole array. While the `holdReset` input is high, the slave acknowledges nothing, so every access is dropped.

Top module: `eeprd_top`

## Requirements
- R1: The first byte after START is taken MSB first. Bits 7:1 are compared with `DEV_ID`, and bit 0 gives the direction (1 = read, 0 = write). The slave acknowledges by pulling SDA low during the ninth SCL high phase, and only when the ID matches.
- R2: After a write-mode device byte, the slave takes an address-high byte and then an address-low byte. It loads the counter with the low `ADDR_W` bits of {high, low} and ignores the upper bits of the high byte. Each further byte is acknowledged and stored at the counter.
- R3: After any byte is read or written at address N, the counter holds N+1. From `2**ADDR_W - 1` it wraps to 0. The counter changes only by this step or by an address load.
- R4: A read-mode device byte with no address set-up returns the byte at the current counter.
- R5: An address set-up, then a repeated START and a read-mode device byte, returns the byte at the loaded address.
- R6: A master acknowledge (SDA low at the ninth SCL rising edge) after a read byte makes the slave send the next sequential byte. A burst may pass the end of the array. With no acknowledge, the slave stops driving and goes idle. The slave leaves SDA released during the master's acknowledge bit.
- R7: While `holdReset` is high, no byte is acknowledged. The transfer is dropped, nothing is written, and the counter is not advanced.
- R8: The slave pulls SDA low only on a change made while SCL is low. In every bit it is not driving a 0, it leaves SDA released (`sdaOut` = 1).
- R9: A START or STOP in the middle of a byte ends that transfer at once. A START begins a new device byte, and a STOP returns the slave to idle. The counter and the memory keep their values.
- R10: During and after reset the slave releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Bus clock, synchronised to clk |
| sdaIn | input | 1 | Resolved bus data line, synchronised to clk |
| holdReset | input | 1 | High: refuse to acknowledge any byte |
| sdaOut | output | 1 | Open-drain data drive: 0 pulls low, 1 releases |

## Verification
On every cycle the assertions check these behaviours:
- SDA is pulled low only after SCL was low.
- The acknowledge drive appears only in the ninth bit and never starts while `holdReset` is high.
- The counter moves only by one step, modulo the array size, or by a load.
- SDA stays released in the master's acknowledge slot.
- A STOP always leads to idle.

Only the bench's scenarios can show that the bytes come back right. That covers the current, random and wrapping sequential reads, the masking of unused address bits, and the refused write under hold. It also covers the fact that an aborted byte leaves the counter and the memory as they were.

// File: rtl/eeprd_pkg.sv
package eeprd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } phase_e;

  typedef struct packed {
    logic loadHi;
    logic loadAddr;
    logic wrByte;
    logic loadTx;
    logic shiftTx;
  } dp_strobe_t;

endpackage

// File: rtl/eeprd_ctrl.sv
module eeprd_ctrl
  import eeprd_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'h50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic       holdReset,
  output dp_strobe_t strobe,
  output logic [7:0] rxByte,
  output logic       driveAck,
  output logic       driveData,
  output phase_e     state,
  output logic [3:0] bitCnt
);

  logic prevScl, prevSda, isRead, masterAck;
  logic sclRise, sclFall, startEv, stopEv, accept;
  logic [7:0] rxShift;
  phase_e nextAfterAck;

  assign sclRise = scl & ~prevScl;
  assign sclFall = ~scl & prevScl;
  assign startEv = scl & prevScl & prevSda & ~sdaIn;
  assign stopEv  = scl & prevScl & ~prevSda & sdaIn;
  assign rxByte  = rxShift;

  // A received byte is acknowledged when the phase allows it and the hold input is low
  assign accept = ~holdReset &
                  (((state == ST_DEV) && (rxShift[7:1] == DEV_ID)) ||
                   (state == ST_AHI) || (state == ST_ALO) || (state == ST_WR));

  always_comb begin
    case (state)
      ST_DEV:  nextAfterAck = isRead ? ST_RD : ST_AHI;
      ST_AHI:  nextAfterAck = ST_ALO;
      default: nextAfterAck = ST_WR;
    endcase
  end

  // Strobes toward the datapath, all issued on a falling SCL
  always_comb begin
    strobe = '0;
    if (sclFall) begin
      if ((bitCnt == 4'd8) && accept) begin
        strobe.loadHi   = (state == ST_AHI);
        strobe.loadAddr = (state == ST_ALO);
        strobe.wrByte   = (state == ST_WR);
      end
      if ((bitCnt == 4'd9) &&
          ((driveAck && (nextAfterAck == ST_RD)) || ((state == ST_RD) && masterAck)))
        strobe.loadTx = 1'b1;
      if ((state == ST_RD) && (bitCnt >= 4'd1) && (bitCnt <= 4'd7))
        strobe.shiftTx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevScl   <= 1'b1;
      prevSda   <= 1'b1;
      state     <= ST_IDLE;
      bitCnt    <= 4'd0;
      rxShift   <= 8'd0;
      driveAck  <= 1'b0;
      driveData <= 1'b0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      prevScl <= scl;
      prevSda <= sdaIn;
      if (startEv) begin
        state     <= ST_DEV;
        bitCnt    <= 4'd0;
        driveAck  <= 1'b0;
        driveData <= 1'b0;
      end else if (stopEv) begin
        state     <= ST_IDLE;
        driveAck  <= 1'b0;
        driveData <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (sclRise) begin
          rxShift <= {rxShift[6:0], sdaIn};
          bitCnt  <= bitCnt + 4'd1;
          if ((state == ST_RD) && (bitCnt == 4'd8)) masterAck <= ~sdaIn;
        end else if (sclFall) begin
          if (bitCnt == 4'd8) begin
            if (state == ST_RD) begin
              driveData <= 1'b0;
            end else if (accept) begin
              driveAck <= 1'b1;
              if (state == ST_DEV) isRead <= rxShift[0];
            end else begin
              state <= ST_IDLE;
            end
          end else if (bitCnt == 4'd9) begin
            bitCnt   <= 4'd0;
            driveAck <= 1'b0;
            if (state == ST_RD) begin
              if (masterAck) driveData <= 1'b1;
              else           state     <= ST_IDLE;
            end else begin
              state     <= nextAfterAck;
              driveData <= (nextAfterAck == ST_RD);
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/eeprd_datapath.sv
module eeprd_datapath
  import eeprd_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [7:0]        rxByte,
  output logic              txBit,
  output logic [ADDR_W-1:0] addrCnt
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  logic [7:0]      mem [DEPTH];
  logic [7:0]      rdData, txShift;
  logic [HI_W-1:0] addrHi;

  // Array port: write at the counter, and read the counter's byte one cycle later
  always_ff @(posedge clk) begin
    if (strobe.wrByte) mem[addrCnt] <= rxByte;
    rdData <= mem[addrCnt];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHi  <= '0;
      addrCnt <= '0;
      txShift <= 8'hFF;
    end else begin
      if (strobe.loadHi) addrHi <= rxByte[HI_W-1:0];
      if (strobe.loadAddr)
        addrCnt <= {addrHi, rxByte};
      else if (strobe.wrByte || strobe.loadTx)
        addrCnt <= addrCnt + 1'b1;
      if (strobe.loadTx)
        txShift <= rdData;
      else if (strobe.shiftTx)
        txShift <= {txShift[6:0], 1'b1};
    end
  end

  assign txBit = txShift[7];

endmodule

// File: rtl/eeprd_top.sv
module eeprd_top
  import eeprd_pkg::*;
#(
  parameter int         ADDR_W = 11,
  parameter logic [6:0] DEV_ID = 7'h50
) (
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sdaIn,
  input  logic holdReset,
  output logic sdaOut
);

  dp_strobe_t        strobe;
  logic [7:0]        rxByte;
  logic              driveAck, driveData, txBit;
  phase_e            ctrlState;
  logic [3:0]        bitCnt;
  logic [ADDR_W-1:0] addrCnt;

  eeprd_ctrl #(.DEV_ID(DEV_ID)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .scl       (scl),
    .sdaIn     (sdaIn),
    .holdReset (holdReset),
    .strobe    (strobe),
    .rxByte    (rxByte),
    .driveAck  (driveAck),
    .driveData (driveData),
    .state     (ctrlState),
    .bitCnt    (bitCnt)
  );

  eeprd_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rxByte  (rxByte),
    .txBit   (txBit),
    .addrCnt (addrCnt)
  );

  assign sdaOut = ~driveAck & (~driveData | txBit);

endmodule

// File: rtl/eeprd_checker.sv
module eeprd_checker
  import eeprd_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              scl,
  input logic              sdaIn,
  input logic              sdaOut,
  input logic              holdReset,
  input logic              driveAck,
  input logic              loadAddrStb,
  input phase_e            state,
  input logic [3:0]        bitCnt,
  input logic [ADDR_W-1:0] addrCnt
);

  logic              chkScl, chkSda, stopSeen;
  logic [ADDR_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkScl <= 1'b1;
      chkSda <= 1'b1;
    end else begin
      chkScl <= scl;
      chkSda <= sdaIn;
    end
  end

  assign stopSeen = scl & chkScl & ~chkSda & sdaIn;
  assign stepCnt  = addrCnt + 1'b1;

  // R8: the slave pulls SDA low only after a cycle with SCL low
  p_sda_fall_low_scl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOut) |-> !$past(scl));

  // R1: the acknowledge drive appears only in the ninth bit
  p_ack_in_slot_r1: assert property (@(posedge clk) disable iff (!rstN)
    driveAck |-> (bitCnt >= 4'd8));

  // R7: no acknowledge starts while the hold input is high
  p_no_ack_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveAck) |-> !$past(holdReset));

  // R3: the counter moves by one step modulo the array size, or by a load
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(addrCnt) |-> ((addrCnt == $past(stepCnt)) || $past(loadAddrStb)));

  // R6: SDA stays released in the master's acknowledge slot
  p_mack_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RD) && (bitCnt == 4'd9)) |-> sdaOut);

  // R9: a STOP returns the slave to idle
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (state == ST_IDLE));

endmodule

bind eeprd_top eeprd_checker #(.ADDR_W(ADDR_W)) u_eeprd_checker (
  .clk         (clk),
  .rstN        (rstN),
  .scl         (scl),
  .sdaIn       (sdaIn),
  .sdaOut      (sdaOut),
  .holdReset   (holdReset),
  .driveAck    (driveAck),
  .loadAddrStb (strobe.loadAddr),
  .state       (ctrlState),
  .bitCnt      (bitCnt),
  .addrCnt     (addrCnt)
);

// File: tb/test_eeprd_top.sv
module test_eeprd_top;

  localparam int         AW    = 9;
  localparam int         DEPTH = 1 << AW;
  localparam logic [6:0] DEV   = 7'h53;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic holdReset = 1'b0;
  logic sdaOut;
  logic bus;

  assign bus = mSda & sdaOut;

  always #4 clk = ~clk;

  eeprd_top #(.ADDR_W(AW), .DEV_ID(DEV)) i_eeprd_top (
    .clk       (clk),
    .rstN      (rstN),
    .scl       (scl),
    .sdaIn     (bus),
    .holdReset (holdReset),
    .sdaOut    (sdaOut)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] model [DEPTH];

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29) + (a >> 8) * 91);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; tk(2);
    scl = 1'b1;  tk(2);
    mSda = 1'b0; tk(2);
    scl = 1'b0;  tk(2);
  endtask

  task automatic busStop();
    mSda = 1'b0; tk(2);
    scl = 1'b1;  tk(2);
    mSda = 1'b1; tk(2);
  endtask

  task automatic sendBit(logic b);
    mSda = b;   tk(2);
    scl = 1'b1; tk(2);
    scl = 1'b0; tk(2);
  endtask

  task automatic sendByte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    mSda = 1'b1; tk(2);
    scl = 1'b1;  tk(1);
    ack = ~bus;  tk(1);
    scl = 1'b0;  tk(2);
  endtask

  task automatic readByte(logic giveAck, output logic [7:0] d, output logic rel);
    for (int i = 7; i >= 0; i--) begin
      mSda = 1'b1; tk(2);
      scl = 1'b1;  tk(1);
      d[i] = bus;  tk(1);
      scl = 1'b0;  tk(2);
    end
    mSda = ~giveAck; tk(2);
    scl = 1'b1;      tk(1);
    rel = sdaOut;    tk(1);
    scl = 1'b0;      tk(2);
  endtask

  task automatic setAddr(int a, logic [7:0] junk);
    logic ack;
    busStart();
    sendByte({DEV, 1'b0}, ack);
    check(ack, "R1 devW", ack, 1);
    sendByte({junk[7:1], a[8]}, ack);
    check(ack, "R2 addrHi", ack, 1);
    sendByte(a[7:0], ack);
    check(ack, "R2 addrLo", ack, 1);
  endtask

  task automatic currentRead(output logic [7:0] d);
    logic ack, rel;
    busStart();
    sendByte({DEV, 1'b1}, ack);
    check(ack, "R4 devR", ack, 1);
    readByte(1'b0, d, rel);
    check(rel, "R6 release", rel, 1);
    busStop();
  endtask

  task automatic randomRead(int a, logic [7:0] junk, output logic [7:0] d);
    logic ack, rel;
    setAddr(a, junk);
    busStart();
    sendByte({DEV, 1'b1}, ack);
    check(ack, "R5 devR", ack, 1);
    readByte(1'b0, d, rel);
    busStop();
  endtask

  bit done = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ack, rel;
    logic [7:0] d;
    int a;

    // R10: reset state
    tk(5);
    check(sdaOut == 1'b1, "R10 in reset", sdaOut, 1);
    rstN = 1'b1;
    tk(3);
    check(sdaOut == 1'b1, "R10 after reset", sdaOut, 1);

    // R1: sweep every device ID in write mode
    for (int id = 0; id < 128; id++) begin
      busStart();
      sendByte({7'(id), 1'b0}, ack);
      check(ack == (7'(id) == DEV), "R1 id sweep", ack, 7'(id) == DEV);
      busStop();
    end

    // R2: fill the whole array in one burst, with junk above the used high bit
    setAddr(0, 8'hFE);
    for (int i = 0; i < DEPTH; i++) begin
      sendByte(pat(i), ack);
      check(ack, "R2 data ack", ack, 1);
      model[i] = pat(i);
    end
    busStop();

    // R3: the counter wrapped to 0 after the last write
    currentRead(d);
    check(d == model[0], "R3 write wrap", d, model[0]);
    currentRead(d);
    check(d == model[1], "R4 current read", d, model[1]);

    // R5: random reads, then a current read of the next byte
    for (int i = 0; i < 16; i++) begin
      case (i)
        0: a = 0;
        1: a = 255;
        2: a = 256;
        3: a = DEPTH - 1;
        default: a = (i * 173) % DEPTH;
      endcase
      randomRead(a, 8'(i * 22 + 6), d);
      check(d == model[a], "R5 random read", d, model[a]);
      currentRead(d);
      check(d == model[(a + 1) % DEPTH], "R3 next after read", d, model[(a + 1) % DEPTH]);
    end

    // R6: a sequential burst that passes the end of the array
    setAddr(496, 8'h00);
    busStart();
    sendByte({DEV, 1'b1}, ack);
    check(ack, "R6 devR", ack, 1);
    for (int i = 0; i < 520; i++) begin
      readByte(i != 519, d, rel);
      check(d == model[(496 + i) % DEPTH], "R6 burst data", d, model[(496 + i) % DEPTH]);
      check(rel, "R8 release in master ack", rel, 1);
    end
    tk(2);
    check(sdaOut == 1'b1, "R6 idle after nack", sdaOut, 1);
    busStop();
    currentRead(d);
    check(d == model[(496 + 520) % DEPTH], "R6 counter after burst", d, model[(496 + 520) % DEPTH]);

    // R7: the hold input blocks every acknowledge
    holdReset = 1'b1;
    busStart();
    sendByte({DEV, 1'b1}, ack);
    check(!ack, "R7 hold read", ack, 0);
    busStop();
    busStart();
    sendByte({DEV, 1'b0}, ack);
    check(!ack, "R7 hold write", ack, 0);
    busStop();
    holdReset = 1'b0;
    setAddr(170, 8'h00);
    holdReset = 1'b1;
    sendByte(8'h5C, ack);
    check(!ack, "R7 hold data", ack, 0);
    busStop();
    holdReset = 1'b0;
    currentRead(d);
    check(d == model[170], "R7 no write, counter kept", d, model[170]);

    // R3: a write at the top address wraps the counter
    setAddr(DEPTH - 1, 8'h00);
    sendByte(8'hC3, ack);
    check(ack, "R2 single write", ack, 1);
    model[DEPTH - 1] = 8'hC3;
    busStop();
    currentRead(d);
    check(d == model[0], "R3 wrap after write", d, model[0]);
    randomRead(DEPTH - 1, 8'h00, d);
    check(d == 8'hC3, "R2 written byte", d, 8'hC3);

    // R9: a STOP in the middle of the address byte keeps the counter at 0
    busStart();
    sendByte({DEV, 1'b0}, ack);
    sendByte(8'h01, ack);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    busStop();
    currentRead(d);
    check(d == model[0], "R9 stop abort", d, model[0]);

    // R9: a repeated START in the middle of a data byte writes nothing
    setAddr(85, 8'h00);
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b1);
    busStart();
    sendByte({DEV, 1'b1}, ack);
    check(ack, "R9 restart devR", ack, 1);
    readByte(1'b0, d, rel);
    check(d == model[85], "R9 start abort", d, model[85]);
    busStop();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule